// File: doc/BRIEF.md
# Streaming Error-Bit Mapping Adapter

This block sits between a ready/valid streaming source and a streaming sink whose error vectors disagree. It has no clock. Data, valid, start-of-packet and end-of-packet flow from the upstream side to the downstream side unchanged. Ready flows back from the downstream side to the upstream side. Every one of these signals has the same width on both sides.

Only the error vector is rebuilt. Each error bit on each side carries a small integer type code, set by a packed parameter map. Code 0 is reserved and means "catch-all". Bit n of a side takes its code from bits [n*TYPE_W +: TYPE_W] of that side's map. All routing is worked out at elaboration, so the hardware is only wires plus one OR tree.

A side may have zero error bits. Its error port then stays one bit wide: on the upstream side that pad bit is ignored, and on the downstream side it is held at 0.

Top module: `err_map_adapter`

## Requirements
- R1: dn_data, dn_valid, dn_sop and dn_eop always equal up_data, up_valid, up_sop and up_eop.
- R2: up_ready always equals dn_ready.
- R3: A downstream error bit with a nonzero code copies the lowest-index upstream bit that has the same code and is not already claimed. Claims are made in order of ascending downstream index, and each upstream bit can be claimed only once.
- R4: The lowest-index downstream bit with code 0 carries the OR of every upstream error bit that no bit claimed under R3, whatever the code of that upstream bit.
- R5: Every downstream bit with code 0 other than the lowest-index one is held at 0.
- R6: A downstream bit with a nonzero code that finds no free upstream bit of that code is held at 0.
- R7: An upstream bit that is not claimed, when the downstream side has no code-0 bit, has no effect on dn_err.
- R8: When IN_ERR_W is 0, every dn_err bit is 0. When OUT_ERR_W is 0, the one-bit dn_err pad is 0.
- R9: The number of set dn_err bits never exceeds the number of set up_err bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| up_data | input | DATA_W | Payload from the source |
| up_valid | input | 1 | Source valid |
| up_sop | input | 1 | Source start of packet |
| up_eop | input | 1 | Source end of packet |
| up_err | input | max(IN_ERR_W,1) | Source error bits |
| up_ready | output | 1 | Ready returned to the source |
| dn_data | output | DATA_W | Payload to the sink |
| dn_valid | output | 1 | Valid to the sink |
| dn_sop | output | 1 | Start of packet to the sink |
| dn_eop | output | 1 | End of packet to the sink |
| dn_err | output | max(OUT_ERR_W,1) | Remapped error bits to the sink |
| dn_ready | input | 1 | Ready from the sink |

## Verification
The bench builds four copies of the block.

The first copy uses four upstream bits coded 1,2,2,0 and five downstream bits coded 2,2,0,0,7. This puts a repeated code claimed twice (R3), an upstream catch-all folded into the OR (R4), a second catch-all held at 0 (R5) and an unmatched code (R6) all within reach.

The second copy maps three upstream bits coded 1,2,3 to two downstream bits coded 3,1. It has no catch-all, so its middle upstream bit must be dropped (R7).

The third copy has zero upstream bits. The fourth has zero downstream bits. Together they cover both empty-side cases (R8).

// File: rtl/err_map_pkg.sv
package err_map_pkg;
    // Reserved type code: the catch-all error class
    localparam int ERR_OTHER = 0;

    // Physical port width for a vector that may be logically empty
    function automatic int pw(input int w);
        return (w > 0) ? w : 1;
    endfunction
endpackage

// File: rtl/stream_pass.sv
module stream_pass #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] i_data,
    input  logic              i_valid,
    input  logic              i_sop,
    input  logic              i_eop,
    output logic              i_ready,
    output logic [DATA_W-1:0] o_data,
    output logic              o_valid,
    output logic              o_sop,
    output logic              o_eop,
    input  logic              o_ready
);
    // Forward direction
    assign o_data  = i_data;
    assign o_valid = i_valid;
    assign o_sop   = i_sop;
    assign o_eop   = i_eop;
    // Backpressure runs against the data
    assign i_ready = o_ready;
endmodule

// File: rtl/err_remap.sv
module err_remap #(
    parameter int IN_ERR_W  = 4,
    parameter int OUT_ERR_W = 5,
    parameter int TYPE_W    = 4,
    parameter logic [err_map_pkg::pw(IN_ERR_W)*TYPE_W-1:0]  IN_TYPE_MAP  = '0,
    parameter logic [err_map_pkg::pw(OUT_ERR_W)*TYPE_W-1:0] OUT_TYPE_MAP = '0
) (
    input  logic [err_map_pkg::pw(IN_ERR_W)-1:0]  in_err,
    output logic [err_map_pkg::pw(OUT_ERR_W)-1:0] out_err
);
    import err_map_pkg::*;

    localparam int IN_PW  = pw(IN_ERR_W);
    localparam int OUT_PW = pw(OUT_ERR_W);

    function automatic int in_code(input int i);
        return int'(IN_TYPE_MAP[i*TYPE_W +: TYPE_W]);
    endfunction

    function automatic int out_code(input int k);
        return int'(OUT_TYPE_MAP[k*TYPE_W +: TYPE_W]);
    endfunction

    // Upstream bit claimed by downstream bit j, or -1 if none
    function automatic int src_for(input int j);
        logic [IN_PW-1:0] taken;
        int pick;
        taken = '0;
        pick  = -1;
        for (int k = 0; k <= j && k < OUT_ERR_W; k++) begin
            pick = -1;
            if (out_code(k) != ERR_OTHER) begin
                for (int i = 0; i < IN_ERR_W; i++) begin
                    if (pick < 0 && !taken[i] && in_code(i) == out_code(k))
                        pick = i;
                end
            end
            if (pick >= 0)
                taken[pick] = 1'b1;
        end
        return pick;
    endfunction

    // Upstream bits left unclaimed after all direct pairings
    function automatic logic [IN_PW-1:0] left_mask();
        logic [IN_PW-1:0] m;
        m = '0;
        for (int i = 0; i < IN_ERR_W; i++)
            m[i] = 1'b1;
        for (int k = 0; k < OUT_ERR_W; k++) begin
            if (src_for(k) >= 0)
                m[src_for(k)] = 1'b0;
        end
        return m;
    endfunction

    function automatic int first_other();
        int f;
        f = -1;
        for (int k = OUT_ERR_W - 1; k >= 0; k--) begin
            if (out_code(k) == ERR_OTHER)
                f = k;
        end
        return f;
    endfunction

    localparam logic [IN_PW-1:0] LEFT_MASK = left_mask();
    localparam int               CATCH_IDX = first_other();

    logic leftover_or;
    assign leftover_or = |(in_err & LEFT_MASK);

    for (genvar j = 0; j < OUT_PW; j++) begin : g_bit
        localparam int SRC = src_for(j);
        if (j >= OUT_ERR_W) begin : g_pad
            assign out_err[j] = 1'b0;
        end else if (SRC >= 0) begin : g_direct
            assign out_err[j] = in_err[SRC];
        end else if (j == CATCH_IDX) begin : g_catch
            assign out_err[j] = leftover_or;
        end else begin : g_tie
            assign out_err[j] = 1'b0;
        end
    end

    // Bits that feed nothing are deliberately dropped
    logic unused_in;
    assign unused_in = ^in_err;
endmodule

// File: rtl/err_map_adapter.sv
module err_map_adapter #(
    parameter int DATA_W    = 8,
    parameter int IN_ERR_W  = 4,
    parameter int OUT_ERR_W = 5,
    parameter int TYPE_W    = 4,
    parameter logic [err_map_pkg::pw(IN_ERR_W)*TYPE_W-1:0]  IN_TYPE_MAP  = 16'h0221,
    parameter logic [err_map_pkg::pw(OUT_ERR_W)*TYPE_W-1:0] OUT_TYPE_MAP = 20'h70022
) (
    input  logic [DATA_W-1:0]                     up_data,
    input  logic                                  up_valid,
    input  logic                                  up_sop,
    input  logic                                  up_eop,
    input  logic [err_map_pkg::pw(IN_ERR_W)-1:0]  up_err,
    output logic                                  up_ready,
    output logic [DATA_W-1:0]                     dn_data,
    output logic                                  dn_valid,
    output logic                                  dn_sop,
    output logic                                  dn_eop,
    output logic [err_map_pkg::pw(OUT_ERR_W)-1:0] dn_err,
    input  logic                                  dn_ready
);
    stream_pass #(
        .DATA_W (DATA_W)
    ) u_pass (
        .i_data  (up_data),
        .i_valid (up_valid),
        .i_sop   (up_sop),
        .i_eop   (up_eop),
        .i_ready (up_ready),
        .o_data  (dn_data),
        .o_valid (dn_valid),
        .o_sop   (dn_sop),
        .o_eop   (dn_eop),
        .o_ready (dn_ready)
    );

    err_remap #(
        .IN_ERR_W     (IN_ERR_W),
        .OUT_ERR_W    (OUT_ERR_W),
        .TYPE_W       (TYPE_W),
        .IN_TYPE_MAP  (IN_TYPE_MAP),
        .OUT_TYPE_MAP (OUT_TYPE_MAP)
    ) u_remap (
        .in_err  (up_err),
        .out_err (dn_err)
    );
endmodule

// File: rtl/err_map_adapter_chk.sv
module err_map_adapter_chk #(
    parameter int DATA_W    = 8,
    parameter int IN_ERR_W  = 4,
    parameter int OUT_ERR_W = 5
) (
    input logic [DATA_W-1:0]                     up_data,
    input logic                                  up_valid,
    input logic                                  up_sop,
    input logic                                  up_eop,
    input logic [err_map_pkg::pw(IN_ERR_W)-1:0]  up_err,
    input logic                                  up_ready,
    input logic [DATA_W-1:0]                     dn_data,
    input logic                                  dn_valid,
    input logic                                  dn_sop,
    input logic                                  dn_eop,
    input logic [err_map_pkg::pw(OUT_ERR_W)-1:0] dn_err,
    input logic                                  dn_ready
);
    always_comb begin
        assert_fwd_pass_R1: assert ({dn_data, dn_valid, dn_sop, dn_eop} ==
                                    {up_data, up_valid, up_sop, up_eop});
        assert_ready_back_R2: assert (up_ready == dn_ready);
        assert_no_excess_R9: assert ($countones(dn_err) <= $countones(up_err));
        assert_quiet_in_R6: assert ((IN_ERR_W > 0 && up_err != '0) || dn_err == '0);
        if (OUT_ERR_W == 0)
            assert_empty_out_R8: assert (dn_err == '0);
    end
endmodule

bind err_map_adapter err_map_adapter_chk #(
    .DATA_W    (DATA_W),
    .IN_ERR_W  (IN_ERR_W),
    .OUT_ERR_W (OUT_ERR_W)
) u_chk (.*);

// File: tb/err_map_adapter_bench.sv
module err_map_adapter_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] up_data;
    logic up_valid, up_sop, up_eop, dn_ready;
    logic [3:0] ea_in;
    logic [2:0] eb_in;
    logic       ec_in;
    logic [1:0] ed_in;

    logic [7:0] da, db, dc, dd;
    logic va, vb, vc, vd, sa, sb, sc, sd, ea, eb, ec, ed;
    logic ra, rb, rc, rd;
    logic [4:0] oa;
    logic [1:0] ob;
    logic [1:0] oc;
    logic       od;

    // A: in codes 1,2,2,0 ; out codes 2,2,0,0,7
    err_map_adapter u_err_map_adapter (
        .up_data(up_data), .up_valid(up_valid), .up_sop(up_sop), .up_eop(up_eop),
        .up_err(ea_in), .up_ready(ra), .dn_data(da), .dn_valid(va), .dn_sop(sa),
        .dn_eop(ea), .dn_err(oa), .dn_ready(dn_ready));

    // B: in codes 1,2,3 ; out codes 3,1 (no catch-all)
    err_map_adapter #(.IN_ERR_W(3), .OUT_ERR_W(2),
        .IN_TYPE_MAP(12'h321), .OUT_TYPE_MAP(8'h13)) u_err_map_adapter_b (
        .up_data(up_data), .up_valid(up_valid), .up_sop(up_sop), .up_eop(up_eop),
        .up_err(eb_in), .up_ready(rb), .dn_data(db), .dn_valid(vb), .dn_sop(sb),
        .dn_eop(eb), .dn_err(ob), .dn_ready(dn_ready));

    // C: no upstream error bits ; out codes 0,4
    err_map_adapter #(.IN_ERR_W(0), .OUT_ERR_W(2),
        .IN_TYPE_MAP(4'h0), .OUT_TYPE_MAP(8'h40)) u_err_map_adapter_c (
        .up_data(up_data), .up_valid(up_valid), .up_sop(up_sop), .up_eop(up_eop),
        .up_err(ec_in), .up_ready(rc), .dn_data(dc), .dn_valid(vc), .dn_sop(sc),
        .dn_eop(ec), .dn_err(oc), .dn_ready(dn_ready));

    // D: in codes 1,0 ; no downstream error bits
    err_map_adapter #(.IN_ERR_W(2), .OUT_ERR_W(0),
        .IN_TYPE_MAP(8'h01), .OUT_TYPE_MAP(4'h0)) u_err_map_adapter_d (
        .up_data(up_data), .up_valid(up_valid), .up_sop(up_sop), .up_eop(up_eop),
        .up_err(ed_in), .up_ready(rd), .dn_data(dd), .dn_valid(vd), .dn_sop(sd),
        .dn_eop(ed), .dn_err(od), .dn_ready(dn_ready));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, written from the requirements per configuration
    task automatic compare_all();
        logic [4:0] xa;
        logic [1:0] xb;
        xa = 5'b0;
        xa[0] = ea_in[1];              // first code-2 sink bit (R3)
        xa[1] = ea_in[2];              // second code-2 sink bit (R3)
        xa[2] = ea_in[0] | ea_in[3];   // catch-all (R4)
        xb = {eb_in[0], eb_in[2]};
        chk("R1 data", {da, va, sa, ea}, {up_data, up_valid, up_sop, up_eop});
        chk("R1 data b", {db, vb, sb, eb, dc, vc, sc, ec, dd, vd, sd, ed},
            {3{up_data, up_valid, up_sop, up_eop}});
        chk("R2 ready", {ra, rb, rc, rd}, {4{dn_ready}});
        chk("R3 R4 R5 R6 err A", 32'(oa), 32'(xa));
        chk("R7 err B", 32'(ob), 32'(xb));
        chk("R8 empty in", 32'(oc), 32'h0);
        chk("R8 empty out", 32'(od), 32'h0);
        chk("R9 count", 32'($countones(oa) <= $countones(ea_in)), 32'h1);
    endtask

    task automatic drive(input logic [3:0] a, input logic [2:0] b, input logic [1:0] d);
        @(posedge clk);
        ea_in = a; eb_in = b; ed_in = d; ec_in = 1'b1;
        up_data = 8'($urandom); up_valid = 1'($urandom); up_sop = 1'($urandom);
        up_eop = 1'($urandom); dn_ready = 1'($urandom);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        up_data = '0; up_valid = 0; up_sop = 0; up_eop = 0; dn_ready = 0;
        ea_in = '0; eb_in = '0; ec_in = 0; ed_in = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 idle A", 32'(oa), 32'h0);
        chk("R2 idle ready", 32'(ra), 32'h0);
        // R3: two sink bits of code 2 claim the two upstream code-2 bits
        drive(4'b0110, 3'b000, 2'b00);
        chk("R3 pair", 32'(oa), 32'h03);
        // R4: upstream code-1 bit alone lands in the catch-all
        drive(4'b0001, 3'b000, 2'b00);
        chk("R4 code1 to catch", 32'(oa), 32'h04);
        // R4: upstream code-0 bit lands in the catch-all; R5 bit 3 stays 0
        drive(4'b1000, 3'b000, 2'b00);
        chk("R5 second catch", 32'(oa[4:3]), 32'h0);
        chk("R4 code0 to catch", 32'(oa), 32'h04);
        // R6: all inputs high, unmatched code 7 and second catch-all stay 0
        drive(4'b1111, 3'b111, 2'b11);
        chk("R6 all high", 32'(oa), 32'h07);
        // R7: dropped middle bit of B has no effect
        drive(4'b0000, 3'b010, 2'b11);
        chk("R7 dropped bit", 32'(ob), 32'h0);
        drive(4'b0000, 3'b101, 2'b00);
        chk("R3 B direct", 32'(ob), 32'h3);
        for (int n = 0; n < 400; n++)
            drive(4'($urandom), 3'($urandom), 2'($urandom));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule